// File: doc/BRIEF.md
# Stochastic Bit-Stream Generator

This block turns an 8-bit binary level (a pixel intensity, a filter weight) into a serial pseudo-random bit stream in which the fraction of ones approaches the level divided by 256. A 9-bit maximal-length shift-register sequence is compared against a level held in a register. Every clock in which a stream is running, the block emits a one if the low eight bits of the sequence are strictly below that level. The stream carries no sign. Downstream logic can read it unipolar (P in [0,1]) or bipolar (2P − 1 in [−1,1]), and the generator is the same for both readings.

Many copies sit side by side, one per operand of a stochastic datapath. Each copy gets its own start state through a parameter, so that streams meeting at the same gate stay uncorrelated. The sequence repeats every 511 states, which is longer than the 256-bit stream, so no pattern repeats inside one stream. A load pulse captures a new level and restarts the stream from the seed. A clear pulse ends the stream.

Top module: `sbs_gen`

## Requirements
- R1: After reset, `valid_o` and `bit_o` are 0, and they stay 0 until the first load.
- R2: A load pulse in clock cycle k makes `valid_o` high from cycle k+1 for exactly `STREAM_LEN` cycles. After those cycles `valid_o` returns to 0, unless another load arrives first.
- R3: The sequence state s is 9 bits wide and is nonzero at all times. On each streaming cycle it steps to {s[7:0], s[8] XOR s[4]}. The first streamed bit uses s equal to the start state, and `bit_o` = (s[7:0] < level) as unsigned numbers.
- R4: `bit_o` is 0 on every cycle in which `valid_o` is 0.
- R5: A level of 0 gives a stream with no ones. A level of 255 gives a one on every cycle except those where s[7:0] equals 255.
- R6: The start state is the `SEED` parameter. A `SEED` of 0 is replaced by 9'h1FF.
- R7: A load while a stream is running restarts the stream. The state returns to the start state and the full `STREAM_LEN` count begins again, so the same level always yields the same bit sequence.
- R8: A clear pulse in cycle k drives `valid_o` and `bit_o` to 0 from cycle k+1. When clear and load are high in the same cycle, clear wins and no stream starts.
- R9: `level_i` is sampled only in a load cycle. Changes to it at any other time have no effect on the running stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| load_i | input | 1 | Capture `level_i`, reseed and start a stream |
| clear_i | input | 1 | End the stream, reseed and zero the stored level |
| level_i | input | 8 | Binary level to be encoded |
| bit_o | output | 1 | Stream bit |
| valid_o | output | 1 | High while a stream bit is being produced |

## Verification
A wrong tap position or a wrong step shows up at `bit_o` within a few cycles of a load for any mid-range level, because the bench compares each bit against its own model of the sequence. A miscounted length shows as `valid_o` falling one cycle early or late at the end of the stream. A stored level that drifts, or a restart that skips the reseed, shows as a mismatch that grows along the stream. A zero seed left in place freezes the sequence, so the output becomes a constant level and differs from the expected stream on the first cycle.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int VAL_W  = 8;
  localparam int LFSR_W = VAL_W + 1;
  localparam int TAP_LO = 4;
  localparam logic [LFSR_W-1:0] SEED_FALLBACK = '1;

  // One step of the x^9 + x^5 + 1 sequence, shifting toward the MSB.
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[TAP_LO]};
  endfunction

  // The all-zero state locks the sequence, so it is mapped to a fixed start.
  function automatic logic [LFSR_W-1:0] seed_fix(input logic [LFSR_W-1:0] s);
    return (s == '0) ? SEED_FALLBACK : s;
  endfunction

  // Stream bit: strict unsigned less-than.
  function automatic logic level_hit(input logic [VAL_W-1:0] rnd,
                                     input logic [VAL_W-1:0] lvl);
    return rnd < lvl;
  endfunction
endpackage

// File: rtl/sbs_lfsr.sv
module sbs_lfsr
  import sbs_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 9'h0B3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reseed,
  input  logic              advance,
  output logic [LFSR_W-1:0] state_o
);
  localparam logic [LFSR_W-1:0] START = seed_fix(SEED);

  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= START;
    else if (reseed)  state_q <= START;
    else if (advance) state_q <= lfsr_next(state_q);
  end

  assign state_o = state_q;

  // R3
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R3
  lfsr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !reseed |=> state_q[LFSR_W-1:1] == $past(state_q[LFSR_W-2:0]));
  // R7
  lfsr_reseed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |=> state_q == START);
endmodule

// File: rtl/sbs_level_cmp.sv
module sbs_level_cmp
  import sbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             clear,
  input  logic [VAL_W-1:0] level_i,
  input  logic [VAL_W-1:0] rnd_i,
  input  logic             active_i,
  output logic             hit_o
);
  logic [VAL_W-1:0] level_q;
  logic             raw_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       level_q <= '0;
    else if (clear)   level_q <= '0;
    else if (capture) level_q <= level_i;
  end

  assign raw_hit = level_hit(rnd_i, level_q);
  assign hit_o   = active_i & raw_hit;

  // R4
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |-> !hit_o);
  // R5
  zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_q == '0 |-> !hit_o);
  // R9
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture && !clear |=> $stable(level_q));
endmodule

// File: rtl/sbs_len_ctr.sv
module sbs_len_ctr #(
  parameter int STREAM_LEN = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic active_o,
  output logic last_o
);
  localparam int CNT_W = (STREAM_LEN > 1) ? $clog2(STREAM_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STREAM_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  assign last_o = active_q && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (stop) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (last_o) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;

  // R2
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
  // R2
  start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !stop |=> active_q);
  // R2
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && !start && !stop |=> !active_q);
  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !active_q);
endmodule

// File: rtl/sbs_gen.sv
module sbs_gen
  import sbs_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED       = 9'h0B3,
  parameter int                STREAM_LEN = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic [VAL_W-1:0] level_i,
  output logic             bit_o,
  output logic             valid_o
);
  logic              start_w;
  logic              reseed_w;
  logic              active_w;
  logic              last_w;
  logic              advance_w;
  logic [LFSR_W-1:0] state_w;
  logic              hit_w;

  assign start_w   = load_i & ~clear_i;
  assign reseed_w  = load_i | clear_i;
  assign advance_w = active_w;

  sbs_len_ctr #(.STREAM_LEN(STREAM_LEN)) len_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_w),
    .stop     (clear_i),
    .active_o (active_w),
    .last_o   (last_w)
  );

  sbs_lfsr #(.SEED(SEED)) lfsr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .reseed  (reseed_w),
    .advance (advance_w),
    .state_o (state_w)
  );

  sbs_level_cmp cmp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (start_w),
    .clear    (clear_i),
    .level_i  (level_i),
    .rnd_i    (state_w[VAL_W-1:0]),
    .active_i (active_w),
    .hit_o    (hit_w)
  );

  assign bit_o   = hit_w;
  assign valid_o = active_w;

  // R2
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |-> valid_o);
  // R8
  clear_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !valid_o && !bit_o);
endmodule

// File: tb/sbs_gen_tb.sv
`timescale 1ns/1ps
module sbs_gen_tb_top;
  localparam real          HALF   = 10.0;
  localparam logic [8:0]   SEED_M = 9'h0B3;
  localparam int           LEN_M  = 256;
  localparam int           LEN_Z  = 16;
  localparam int           NLVL   = 6;
  localparam logic [7:0]   LEVELS [NLVL] = '{8'd0, 8'd1, 8'd64, 8'd128, 8'd200, 8'd255};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_m = 1'b0, clr_m = 1'b0;
  logic [7:0] lvl_m = '0;
  logic       bit_m, val_m;
  logic       load_z = 1'b0, clr_z = 1'b0;
  logic [7:0] lvl_z = '0;
  logic       bit_z, val_z;

  int checks = 0;
  int errors = 0;

  always #(HALF) clk = ~clk;

  sbs_gen #(.SEED(SEED_M), .STREAM_LEN(LEN_M)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_m), .clear_i(clr_m),
    .level_i(lvl_m), .bit_o(bit_m), .valid_o(val_m));

  sbs_gen #(.SEED(9'h000), .STREAM_LEN(LEN_Z)) dut_z (
    .clk(clk), .rst_n(rst_n), .load_i(load_z), .clear_i(clr_z),
    .level_i(lvl_z), .bit_o(bit_z), .valid_o(val_z));

  // Bench model of the sequence, written from R3.
  function automatic logic [8:0] model_step(input logic [8:0] s);
    logic fb;
    fb = s[8] ^ s[4];
    return (s << 1) | {8'd0, fb};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Load v into the main instance and compare a whole stream.
  // chg_at: cycle index at which level_i is disturbed (-1 = never).
  task automatic run_main(input logic [7:0] v, input int chg_at, input string tag);
    logic [8:0] s;
    int mism, vbad, ones, eones;
    @(negedge clk); load_m = 1'b1; lvl_m = v;
    @(negedge clk); load_m = 1'b0;
    s = SEED_M; mism = 0; vbad = 0; ones = 0; eones = 0;
    for (int i = 0; i < LEN_M; i++) begin
      if (i > 0) @(negedge clk);
      if (i == chg_at) lvl_m = ~v;
      if (bit_m !== (s[7:0] < v)) mism++;
      if (val_m !== 1'b1) vbad++;
      if (bit_m === 1'b1) ones++;
      if (s[7:0] < v) eones++;
      s = model_step(s);
    end
    check(mism == 0, {tag, " stream bits"}, mism, 0);
    check(vbad == 0, "R2 valid held for stream", vbad, 0);
    if (v == 8'd0)   check(ones == 0, "R5 level 0 no ones", ones, 0);
    if (v == 8'd255) check(ones == eones, "R5 level 255 ones", ones, eones);
    @(negedge clk);
    check(val_m == 1'b0, "R2 valid falls after length", int'(val_m), 0);
    check(bit_m == 1'b0, "R4 bit low when idle", int'(bit_m), 0);
  endtask

  initial begin
    #(HALF * 2.0 * 200000.0);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [8:0] s;
    int mism;
    repeat (3) @(negedge clk);
    check(val_m == 1'b0 && bit_m == 1'b0, "R1 main outputs in reset", int'({val_m, bit_m}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(val_m == 1'b0 && bit_m == 1'b0, "R1 main idle after reset", int'({val_m, bit_m}), 0);
    check(val_z == 1'b0 && bit_z == 1'b0, "R1 zero-seed idle after reset", int'({val_z, bit_z}), 0);

    // Table of levels, each checked against the bench model (R3, R5).
    for (int k = 0; k < NLVL; k++) run_main(LEVELS[k], -1, "R3");

    // R9: disturb level_i mid-stream; stream must follow the loaded level.
    run_main(8'd100, 5, "R9");
    lvl_m = 8'd0;

    // R7: reload mid-stream restarts from the seed with a full count.
    @(negedge clk); load_m = 1'b1; lvl_m = 8'd77;
    @(negedge clk); load_m = 1'b0;
    repeat (20) @(negedge clk);
    run_main(8'd77, -1, "R7");

    // R8: clear ends a running stream.
    @(negedge clk); load_m = 1'b1; lvl_m = 8'd250;
    @(negedge clk); load_m = 1'b0;
    repeat (10) @(negedge clk);
    check(val_m == 1'b1, "R8 stream running before clear", int'(val_m), 1);
    clr_m = 1'b1;
    @(negedge clk); clr_m = 1'b0;
    check(val_m == 1'b0 && bit_m == 1'b0, "R8 clear stops stream", int'({val_m, bit_m}), 0);
    // R8: clear beats load in the same cycle.
    load_m = 1'b1; clr_m = 1'b1; lvl_m = 8'd255;
    @(negedge clk); load_m = 1'b0; clr_m = 1'b0;
    check(val_m == 1'b0, "R8 clear wins over load", int'(val_m), 0);
    repeat (4) @(negedge clk);
    check(val_m == 1'b0 && bit_m == 1'b0, "R8 no stream after clear+load", int'({val_m, bit_m}), 0);

    // R6: zero seed replaced by 9'h1FF, short stream of LEN_Z.
    @(negedge clk); load_z = 1'b1; lvl_z = 8'd128;
    @(negedge clk); load_z = 1'b0;
    s = 9'h1FF; mism = 0;
    for (int i = 0; i < LEN_Z; i++) begin
      if (i > 0) @(negedge clk);
      if (bit_z !== (s[7:0] < 8'd128) || val_z !== 1'b1) mism++;
      s = model_step(s);
    end
    check(mism == 0, "R6 zero seed stream", mism, 0);
    @(negedge clk);
    check(val_z == 1'b0, "R2 short stream length", int'(val_z), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule